// File: doc/BRIEF.md
# DDR2 Write Burst Sequencer

This block issues the command and data timing of one write access to a DDR2 memory bank. On an accepted request it opens the row with ACTIVE. It then issues a posted WRITE as soon as the row-to-column delay allows, taking the additive latency into account. After the write latency it presents the burst data as pairs of beats, one pair per clock, and waits out the write recovery time before closing the bank with PRECHARGE. All cycles in between carry NOP.

The data path is described at clock resolution. In each data cycle the beat for the rising strobe edge appears on `dq_rise` and the beat for the falling strobe edge on `dq_fall`. A serializing PHY after this block turns them into double-rate signals. The strobe enable opens one clock early as a preamble and stays on for one clock after the last data cycle. In that last clock the PHY drives the half-clock postamble.

The timing fields (additive latency, CAS latency, row-to-column delay, write recovery, burst length) and the request fields are captured when a request is accepted. Only one access is in flight at a time.

Top module: `ddr2_wr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `dq_oe` and `dqs_oe` are low, `cmd_code` is NOP (3'b000), and `dq_rise`/`dq_fall` are zero.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. In the next cycle (cycle 0) `cmd_code` is ACTIVE (3'b001), with the row on `cmd_addr` and the bank on `cmd_bank`. `busy` is high from cycle 0 through the PRECHARGE cycle and low in the cycle after it. A request presented while `busy` is high starts no access.
- R3: WRITE (3'b010), with the column (zero-extended) on `cmd_addr` and the bank on `cmd_bank`, is issued in cycle G = tRCD − AL when tRCD > AL, and in cycle G = 1 otherwise. Every cycle other than ACTIVE, WRITE and PRECHARGE carries NOP.
- R4: The first data cycle is G + WL, where WL = AL + CL − 1, with a floor of 1. `dq_oe` is high exactly over the data cycles.
- R5: In the i-th data cycle (i from 0), `dq_rise` carries beat 2i and `dq_fall` carries beat 2i+1. Beat b is taken from `req_data[b*DQ_W +: DQ_W]`. With `cfg_bl8` = 0 the burst is 4 beats (2 data cycles); with `cfg_bl8` = 1 it is 8 beats (4 data cycles).
- R6: Outside the data cycles `dq_rise` and `dq_fall` are zero. Beats beyond the selected burst length never appear on the outputs.
- R7: `dqs_oe` is high from one cycle before the first data cycle through one cycle after the last data cycle, and low at all other times.
- R8: PRECHARGE (3'b011), with the bank on `cmd_bank` and zero on `cmd_addr`, is issued WR + 1 cycles after the last data cycle, where WR = `cfg_wr` with a floor of 1.
- R9: The request and configuration inputs are sampled only at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_data | input | BL_MAX*DQ_W | Burst beats, beat 0 in the low bits |
| cfg_al | input | CFG_W | Additive latency in clocks |
| cfg_cl | input | CFG_W | CAS latency in clocks |
| cfg_trcd | input | CFG_W | Row-to-column delay in clocks |
| cfg_wr | input | CFG_W | Write recovery in clocks |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| busy | output | 1 | Access in progress |
| cmd_code | output | 3 | Command: NOP, ACTIVE, WRITE, PRECHARGE |
| cmd_bank | output | BANK_W | Bank for the current command |
| cmd_addr | output | ADDR_W | Row or column for the current command |
| dq_oe | output | 1 | Data drive enable |
| dqs_oe | output | 1 | Strobe drive enable incl. preamble and postamble |
| dq_rise | output | DQ_W | Beat for the rising strobe edge |
| dq_fall | output | DQ_W | Beat for the falling strobe edge |

## Verification
The hardest situations to reach are those where the timing fields interact. One is the clamped WRITE slot when tRCD does not exceed AL. Another is the write latency floor. A third is a strobe preamble that lands on the WRITE cycle itself. The bench reaches all of them by sweeping every combination of AL 0–3, CL 2–5, tRCD 0–4, WR 1–4 and both burst lengths, and it compares every output on every cycle of each access against arithmetic in the bench. On every other access it keeps `req_valid` high with different data and inverted configuration until the PRECHARGE cycle. This shows that nothing is re-sampled mid-access and that no second access starts while `busy` is high.

// File: rtl/ddr2_wr_pkg.sv
// Shared types for the DDR2 write burst sequencer.
// Assumes: command codes are decoded by a downstream PHY/pin stage.
package ddr2_wr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'b000,
        CMD_ACT  = 3'b001,
        CMD_WR   = 3'b010,
        CMD_PRE  = 3'b011
    } cmd_e;

    // Event cycles of one access, counted from the ACTIVE cycle (cycle 0).
    typedef struct packed {
        logic [5:0] t_wr;   // WRITE command cycle
        logic [5:0] t_d0;   // first data cycle
        logic [5:0] t_dl;   // last data cycle
        logic [5:0] t_pre;  // PRECHARGE cycle
    } sched_t;

    localparam int unsigned SCHED_CNT_W = 6;

endpackage

// File: rtl/ddr2_wr_sched.sv
// Computes the event cycles of one access from the timing fields.
// Assumes: CFG_W <= 3 so every event fits the 6-bit cycle count.
module ddr2_wr_sched
    import ddr2_wr_pkg::*;
#(
    parameter int unsigned CFG_W  = 3,
    parameter int unsigned BL_MAX = 8
) (
    input  logic [CFG_W-1:0] cfg_al,
    input  logic [CFG_W-1:0] cfg_cl,
    input  logic [CFG_W-1:0] cfg_trcd,
    input  logic [CFG_W-1:0] cfg_wr,
    input  logic             cfg_bl8,
    output sched_t           sched
);
    localparam int unsigned CW       = SCHED_CNT_W;
    localparam int unsigned NC_LONG  = BL_MAX / 2;
    localparam int unsigned NC_SHORT = BL_MAX / 4;

    logic [CW-1:0] al, cl, trcd, wr_eff, gap, wl, ncyc, latsum;

    // Derive the WRITE slot, write latency, burst span and recovery.
    always_comb begin
        al     = CW'(cfg_al);
        cl     = CW'(cfg_cl);
        trcd   = CW'(cfg_trcd);
        latsum = al + cl;
        gap    = (trcd > al) ? (trcd - al) : CW'(1);
        wl     = (latsum >= CW'(2)) ? (latsum - CW'(1)) : CW'(1);
        ncyc   = cfg_bl8 ? CW'(NC_LONG) : CW'(NC_SHORT);
        wr_eff = (cfg_wr == '0) ? CW'(1) : CW'(cfg_wr);
        sched.t_wr  = gap;
        sched.t_d0  = gap + wl;
        sched.t_dl  = gap + wl + ncyc - CW'(1);
        sched.t_pre = gap + wl + ncyc + wr_eff;
    end

endmodule

// File: rtl/ddr2_wr_ctrl.sv
// Access control: accepts a request, runs the cycle counter and issues
// ACTIVE / WRITE / PRECHARGE at the scheduled cycles, NOP otherwise.
// Assumes: the schedule satisfies 0 < t_wr < t_pre.
module ddr2_wr_ctrl
    import ddr2_wr_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned ADDR_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [ROW_W-1:0]        req_row,
    input  logic [COL_W-1:0]        req_col,
    input  sched_t                  sched_in,
    output logic                    accept,
    output logic                    busy,
    output logic [SCHED_CNT_W-1:0]  cnt,
    output sched_t                  sched_q,
    output logic [2:0]              cmd_code,
    output logic [BANK_W-1:0]       cmd_bank,
    output logic [ADDR_W-1:0]       cmd_addr
);
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    cmd_e              cmd;

    assign accept = req_valid && !busy;

    // Capture the request and count cycles until PRECHARGE has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            sched_q <= '0;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            cnt     <= '0;
            sched_q <= sched_in;
            bank_q  <= req_bank;
            row_q   <= req_row;
            col_q   <= req_col;
        end else if (busy) begin
            if (cnt == sched_q.t_pre) busy <= 1'b0;
            else                      cnt  <= cnt + 1'b1;
        end
    end

    // Decode the current cycle into a command and its address fields.
    always_comb begin
        cmd      = CMD_NOP;
        cmd_addr = '0;
        if (busy) begin
            if (cnt == '0) begin
                cmd      = CMD_ACT;
                cmd_addr = ADDR_W'(row_q);
            end else if (cnt == sched_q.t_wr) begin
                cmd      = CMD_WR;
                cmd_addr = ADDR_W'(col_q);
            end else if (cnt == sched_q.t_pre) begin
                cmd      = CMD_PRE;
            end
        end
        cmd_code = cmd;
        cmd_bank = (cmd == CMD_NOP) ? '0 : bank_q;
    end

endmodule

// File: rtl/ddr2_wr_beats.sv
// Data path: holds the burst, drives one rising/falling beat pair per
// data cycle, and frames the strobe enable with preamble and postamble.
// Assumes: t_d0 >= 1 and t_dl - t_d0 < BL_MAX/2.
module ddr2_wr_beats
    import ddr2_wr_pkg::*;
#(
    parameter int unsigned DQ_W   = 16,
    parameter int unsigned BL_MAX = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [BL_MAX*DQ_W-1:0]  req_data,
    input  logic                    busy,
    input  logic [SCHED_CNT_W-1:0]  cnt,
    input  logic [SCHED_CNT_W-1:0]  t_d0,
    input  logic [SCHED_CNT_W-1:0]  t_dl,
    output logic                    dq_oe,
    output logic                    dqs_oe,
    output logic [DQ_W-1:0]         dq_rise,
    output logic [DQ_W-1:0]         dq_fall
);
    localparam int unsigned PAIRS  = BL_MAX / 2;
    localparam int unsigned PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    logic [DQ_W-1:0]   beat_in   [BL_MAX];
    logic [DQ_W-1:0]   rise_q    [PAIRS];
    logic [DQ_W-1:0]   fall_q    [PAIRS];
    logic [PAIR_W-1:0] pair;

    for (genvar g = 0; g < BL_MAX; g++) begin : g_split
        assign beat_in[g] = req_data[g*DQ_W +: DQ_W];
    end

    // Latch the beats in rising/falling pairs when a request is accepted.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_q[p] <= '0;
                fall_q[p] <= '0;
            end else if (accept) begin
                rise_q[p] <= beat_in[2*p];
                fall_q[p] <= beat_in[2*p+1];
            end
        end
    end

    // Open the data and strobe windows and select the current beat pair.
    always_comb begin
        dq_oe   = busy && (cnt >= t_d0) && (cnt <= t_dl);
        dqs_oe  = busy && ((cnt + 1'b1) >= t_d0) && (cnt <= (t_dl + 1'b1));
        pair    = PAIR_W'(cnt - t_d0);
        dq_rise = dq_oe ? rise_q[pair] : '0;
        dq_fall = dq_oe ? fall_q[pair] : '0;
    end

endmodule

// File: rtl/ddr2_wr_seq.sv
// Top of the DDR2 write burst sequencer: one ACTIVE, posted WRITE,
// double-rate burst and write-recovery-gated PRECHARGE per request.
// Assumes: one access at a time; fields sampled at acceptance.
module ddr2_wr_seq
    import ddr2_wr_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned DQ_W   = 16,
    parameter int unsigned BL_MAX = 8,
    parameter int unsigned CFG_W  = 3,
    localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [BANK_W-1:0]       req_bank,
    input  logic [ROW_W-1:0]        req_row,
    input  logic [COL_W-1:0]        req_col,
    input  logic [BL_MAX*DQ_W-1:0]  req_data,
    input  logic [CFG_W-1:0]        cfg_al,
    input  logic [CFG_W-1:0]        cfg_cl,
    input  logic [CFG_W-1:0]        cfg_trcd,
    input  logic [CFG_W-1:0]        cfg_wr,
    input  logic                    cfg_bl8,
    output logic                    busy,
    output logic [2:0]              cmd_code,
    output logic [BANK_W-1:0]       cmd_bank,
    output logic [ADDR_W-1:0]       cmd_addr,
    output logic                    dq_oe,
    output logic                    dqs_oe,
    output logic [DQ_W-1:0]         dq_rise,
    output logic [DQ_W-1:0]         dq_fall
);
    sched_t                  sched_in, sched_q;
    logic                    accept;
    logic [SCHED_CNT_W-1:0]  cnt;

    ddr2_wr_sched #(.CFG_W(CFG_W), .BL_MAX(BL_MAX)) i_sched (
        .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd),
        .cfg_wr(cfg_wr), .cfg_bl8(cfg_bl8), .sched(sched_in)
    );

    ddr2_wr_ctrl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                   .ADDR_W(ADDR_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sched_in(sched_in), .accept(accept), .busy(busy), .cnt(cnt),
        .sched_q(sched_q), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr)
    );

    ddr2_wr_beats #(.DQ_W(DQ_W), .BL_MAX(BL_MAX)) i_beats (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_data(req_data),
        .busy(busy), .cnt(cnt), .t_d0(sched_q.t_d0), .t_dl(sched_q.t_dl),
        .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dq_rise(dq_rise),
        .dq_fall(dq_fall)
    );

endmodule

// File: rtl/ddr2_wr_seq_chk.sv
// Protocol checker for ddr2_wr_seq, attached by bind.
// Assumes: command codes as listed in the requirements.
module ddr2_wr_seq_chk #(
    parameter int unsigned DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic [2:0]      cmd_code,
    input logic            dq_oe,
    input logic            dqs_oe,
    input logic [DQ_W-1:0] dq_rise,
    input logic [DQ_W-1:0] dq_fall
);
    // R2
    accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (cmd_code == 3'b001));
    // R2
    busy_end_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cmd_code) == 3'b011));
    // R3
    idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd_code == 3'b000));
    // R6
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_rise == '0 && dq_fall == '0));
    // R7
    strobe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> dqs_oe);
    // R7
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $past(dqs_oe));
    // R7
    postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> dqs_oe);
    // R8
    recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'b011) |-> (!dq_oe && !$past(dq_oe)));

endmodule

bind ddr2_wr_seq ddr2_wr_seq_chk #(.DQ_W(DQ_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .cmd_code(cmd_code), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .dq_rise(dq_rise), .dq_fall(dq_fall)
);

// File: tb/test_ddr2_wr_seq.sv
`timescale 1ns/1ps
module test_ddr2_wr_seq;
    localparam int DQ_W = 16;
    localparam int BL   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_bank = '0;
    logic [13:0]     req_row = '0;
    logic [9:0]      req_col = '0;
    logic [BL*DQ_W-1:0] req_data = '0;
    logic [2:0]      cfg_al = '0, cfg_cl = '0, cfg_trcd = '0, cfg_wr = '0;
    logic            cfg_bl8 = 1'b0;
    logic            busy, dq_oe, dqs_oe;
    logic [2:0]      cmd_code, cmd_bank;
    logic [13:0]     cmd_addr;
    logic [DQ_W-1:0] dq_rise, dq_fall;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ddr2_wr_seq i_ddr2_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_data(req_data), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
        .cfg_trcd(cfg_trcd), .cfg_wr(cfg_wr), .cfg_bl8(cfg_bl8),
        .busy(busy), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .dq_rise(dq_rise), .dq_fall(dq_fall)
    );

    task automatic chk(input bit ok, input string tag, input int k,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, k, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] beat_val(input int n, input int b);
        return DQ_W'(n * 613 + b * 4099 + 17);
    endfunction

    // Runs one access and checks every output on every cycle.
    task automatic run_access(input int n, input int al, input int cl,
                              input int trcd, input int wr, input int bl8,
                              input bit noisy);
        int gap, wl, ncyc, d0, dl, tpre, wre, exp_cmd;
        logic [BL*DQ_W-1:0] data;
        logic [2:0]  bank;
        logic [13:0] row;
        logic [9:0]  col;
        gap  = (trcd > al) ? trcd - al : 1;
        wl   = (al + cl >= 2) ? al + cl - 1 : 1;
        ncyc = bl8 ? 4 : 2;
        wre  = (wr == 0) ? 1 : wr;
        d0   = gap + wl;
        dl   = d0 + ncyc - 1;
        tpre = dl + wre + 1;
        for (int b = 0; b < BL; b++) data[b*DQ_W +: DQ_W] = beat_val(n, b);
        bank = 3'(n * 5);
        row  = 14'(n * 97 + 3);
        col  = 10'(n * 29 + 1);
        @(negedge clk);
        req_valid = 1'b1; req_bank = bank; req_row = row; req_col = col;
        req_data = data; cfg_al = 3'(al); cfg_cl = 3'(cl);
        cfg_trcd = 3'(trcd); cfg_wr = 3'(wr); cfg_bl8 = bl8[0];
        for (int k = 0; k <= tpre + 1; k++) begin
            @(negedge clk);
            exp_cmd = (k == 0) ? 1 : (k == gap) ? 2 : (k == tpre) ? 3 : 0;
            if (k == 0)
                chk(cmd_code == 3'b001 && cmd_addr == row && cmd_bank == bank,
                    "R2 ACTIVE", k, {cmd_code, cmd_bank, cmd_addr}, {3'b001, bank, row});
            else if (k == gap)
                chk(cmd_code == 3'b010 && cmd_addr == 14'(col) && cmd_bank == bank,
                    "R3 WRITE", k, {cmd_code, cmd_bank, cmd_addr}, {3'b010, bank, 14'(col)});
            else if (k == tpre)
                chk(cmd_code == 3'b011 && cmd_bank == bank && cmd_addr == '0,
                    "R8 PRECHARGE", k, {cmd_code, cmd_bank}, {3'b011, bank});
            else
                chk(cmd_code == 3'(exp_cmd), "R3 NOP", k, cmd_code, exp_cmd);
            chk(busy == (k <= tpre), "R2 busy", k, busy, k <= tpre);
            chk(dq_oe == (k >= d0 && k <= dl), "R4 dq_oe", k, dq_oe, k >= d0 && k <= dl);
            chk(dqs_oe == (k >= d0 - 1 && k <= dl + 1), "R7 dqs_oe", k,
                dqs_oe, k >= d0 - 1 && k <= dl + 1);
            if (k >= d0 && k <= dl)
                chk(dq_rise == beat_val(n, 2*(k-d0)) && dq_fall == beat_val(n, 2*(k-d0)+1),
                    noisy ? "R9 beats" : "R5 beats", k, {dq_rise, dq_fall},
                    {beat_val(n, 2*(k-d0)), beat_val(n, 2*(k-d0)+1)});
            else
                chk(dq_rise == '0 && dq_fall == '0, "R6 quiet", k,
                    {dq_rise, dq_fall}, 0);
            // Noisy accesses keep a different request pending until PRECHARGE.
            if (noisy && k < tpre) begin
                req_valid = 1'b1; req_bank = ~bank; req_row = ~row; req_col = ~col;
                req_data = ~data; cfg_al = ~3'(al); cfg_cl = ~3'(cl);
                cfg_trcd = ~3'(trcd); cfg_wr = ~3'(wr); cfg_bl8 = ~bl8[0];
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        chk(!busy && cmd_code == 3'b000 && !dq_oe && !dqs_oe && dq_rise == '0 && dq_fall == '0,
            "R1 reset", 0, {busy, cmd_code, dq_oe, dqs_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && cmd_code == 3'b000 && !dq_oe && !dqs_oe,
            "R1 after reset", 0, {busy, cmd_code, dq_oe, dqs_oe}, 0);
        for (int bl8 = 0; bl8 < 2; bl8++)
            for (int wr = 1; wr <= 4; wr++)
                for (int al = 0; al <= 3; al++)
                    for (int cl = 2; cl <= 5; cl++)
                        for (int trcd = 0; trcd <= 4; trcd++) begin
                            run_access(n, al, cl, trcd, wr, bl8, n[0]);
                            n++;
                        end
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule